// File: doc/BRIEF.md
# DMA Request and Acknowledge Handshake for Receive and Transmit FIFOs

This block sits between two data FIFOs and an external DMA controller. The receive side holds words waiting for the host, and the transmit side holds words coming from the host. For each direction it drives an active-high request line. The receive request asks the controller to fetch a word. The transmit request asks it to supply a word. For each direction it takes back an active-low acknowledge. While an acknowledge is low, the host bus access of the matching kind goes straight to that FIFO as a pop or a push. The address decode and chip selects play no part in that access, and the normal register and RAM strobes are held off so that no other location is touched.

The request lines are combinational on the FIFO fill levels and on the access currently in progress. A request therefore falls in the same cycle in which the access begins that takes the last receive word or fills the last transmit slot. The controller sees the request fall early enough not to start a further transfer. The pop, push and decoded strobes are registered one-cycle pulses, one per access start. An acknowledged access that meets an empty receive FIFO or a full transmit FIFO issues no strobe and sets a sticky error flag instead.

Top module: `dma_fifo_handshake`

## Requirements
- R1: `rx_req` is 1 whenever `rx_level` is at least 1 and 0 when it is 0, except as stated in R2.
- R2: While `host_rd` is 1, `rx_ack_n` is 0 and `rx_level` equals 1, `rx_req` is 0 in that same cycle.
- R3: `tx_req` is 1 whenever `tx_level` is below `TX_DEPTH` and 0 when it is at or above it, except as stated in R4.
- R4: While `host_wr` is 1, `tx_ack_n` is 0 and `tx_level` equals `TX_DEPTH`-1, `tx_req` is 0 in that same cycle.
- R5: A read access starts when `host_rd` is 1 after having been 0 in the cycle before. If `rx_ack_n` is 0 at that start and `rx_level` is nonzero, `rx_pop` is 1 in the next cycle. `ram_sel` and `reg_sel` have no effect on this, and `ram_rd` and `reg_rd` stay 0.
- R6: A write access starts when `host_wr` rises in the same way. If `tx_ack_n` is 0 at that start and `tx_level` is below `TX_DEPTH`, `tx_push` is 1 in the next cycle. `ram_sel` and `reg_sel` have no effect on this, and `ram_wr` and `reg_wr` stay 0.
- R7: An acknowledged read start with `rx_level` at 0 gives no `rx_pop` and sets `rx_err` to 1 from the next cycle. `rx_err` then stays 1 until reset.
- R8: An acknowledged write start with `tx_level` at `TX_DEPTH` gives no `tx_push` and sets `tx_err` to 1 from the next cycle. `tx_err` then stays 1 until reset.
- R9: An access start whose acknowledge is 1 produces a strobe in the next cycle. With `ram_sel` at 1 it goes to `ram_rd`/`ram_wr`. With only `reg_sel` at 1 it goes to `reg_rd`/`reg_wr`. With neither select at 1 there is no strobe.
- R10: While `rst` is 1, and in the first cycle after it, all strobes and both error flags are 0.
- R11: Each strobe is a single-cycle pulse per access start. Holding `host_rd` or `host_wr` high for many cycles gives no further strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_level | input | RX_LW | Words held in the receive FIFO |
| tx_level | input | TX_LW | Words held in the transmit FIFO |
| host_rd | input | 1 | Host read access in progress |
| host_wr | input | 1 | Host write access in progress |
| ram_sel | input | 1 | Normal decode hit on the RAM window |
| reg_sel | input | 1 | Normal decode hit on the register window |
| rx_ack_n | input | 1 | Receive acknowledge, active low |
| tx_ack_n | input | 1 | Transmit acknowledge, active low |
| rx_req | output | 1 | Receive DMA request, active high |
| tx_req | output | 1 | Transmit DMA request, active high |
| rx_pop | output | 1 | Pop pulse to the receive FIFO |
| tx_push | output | 1 | Push pulse to the transmit FIFO |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| rx_err | output | 1 | Sticky flag for a pop attempted on an empty receive FIFO |
| tx_err | output | 1 | Sticky flag for a push attempted on a full transmit FIFO |

## Verification
The bench builds the block with a receive depth of 4 and a transmit depth of 5. These shallow FIFOs let the randomly driven fill levels reach empty, full and the one-left boundary many times in a short run. Because the two depths differ, a swap of the depth parameters between the directions shows up as a wrong request. Directed sequences place acknowledged accesses exactly on the last word, on the last slot and on an empty or full FIFO, with both selects asserted.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic {CH_RX = 1'b0, CH_TX = 1'b1} ch_kind_e;

  function automatic int unsigned lvl_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/dma_hs_edge.sv
module dma_hs_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/dma_hs_chan.sv
module dma_hs_chan
  import dma_hs_pkg::*;
#(
  parameter ch_kind_e    KIND  = CH_RX,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = lvl_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level,
  input  logic          act,
  input  logic          ack_n,
  output logic          req,
  output logic          plain_start,
  output logic          xfer,
  output logic          err
);
  logic [LW-1:0] avail;
  logic          start;
  logic          acked_start;
  logic          has_room;
  logic          xfer_q;
  logic          err_q;

  // Units the DMA side can still move: stored words or free slots.
  generate
    if (KIND == CH_RX) begin : g_rx
      assign avail = (level > LW'(DEPTH)) ? LW'(DEPTH) : level;
    end else begin : g_tx
      assign avail = (level >= LW'(DEPTH)) ? '0 : LW'(DEPTH) - level;
    end
  endgenerate

  dma_hs_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (act),
    .rise_o (start)
  );

  assign has_room    = (avail != '0);
  assign acked_start = start & ~ack_n;
  assign plain_start = start & ack_n;

  // Drop the request as soon as the access taking the final unit is seen.
  assign req = has_room & ~((avail == LW'(1)) & act & ~ack_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      xfer_q <= acked_start & has_room;
      err_q  <= err_q | (acked_start & ~has_room);
    end
  end

  assign xfer = xfer_q;
  assign err  = err_q;
endmodule

// File: rtl/dma_hs_decode.sv
module dma_hs_decode #(
  parameter int unsigned NDIR = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDIR-1:0] go,
  input  logic            ram_sel,
  input  logic            reg_sel,
  output logic [NDIR-1:0] ram_stb,
  output logic [NDIR-1:0] reg_stb
);
  logic [NDIR-1:0] ram_q;
  logic [NDIR-1:0] reg_q;

  // One registered strobe per direction; the RAM window has priority.
  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      always_ff @(posedge clk) begin
        if (rst) begin
          ram_q[d] <= 1'b0;
          reg_q[d] <= 1'b0;
        end else begin
          ram_q[d] <= go[d] & ram_sel;
          reg_q[d] <= go[d] & ~ram_sel & reg_sel;
        end
      end
    end
  endgenerate

  assign ram_stb = ram_q;
  assign reg_stb = reg_q;
endmodule

// File: rtl/dma_fifo_handshake.sv
module dma_fifo_handshake
  import dma_hs_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned TX_DEPTH = 16,
  localparam int unsigned RX_LW   = lvl_width(RX_DEPTH),
  localparam int unsigned TX_LW   = lvl_width(TX_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RX_LW-1:0] rx_level,
  input  logic [TX_LW-1:0] tx_level,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic             ram_sel,
  input  logic             reg_sel,
  input  logic             rx_ack_n,
  input  logic             tx_ack_n,
  output logic             rx_req,
  output logic             tx_req,
  output logic             rx_pop,
  output logic             tx_push,
  output logic             ram_rd,
  output logic             ram_wr,
  output logic             reg_rd,
  output logic             reg_wr,
  output logic             rx_err,
  output logic             tx_err
);
  localparam int unsigned DIR_RD = 0;
  localparam int unsigned DIR_WR = 1;

  logic [1:0] plain_go;
  logic [1:0] ram_stb;
  logic [1:0] reg_stb;

  dma_hs_chan #(.KIND(CH_RX), .DEPTH(RX_DEPTH)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .level       (rx_level),
    .act         (host_rd),
    .ack_n       (rx_ack_n),
    .req         (rx_req),
    .plain_start (plain_go[DIR_RD]),
    .xfer        (rx_pop),
    .err         (rx_err)
  );

  dma_hs_chan #(.KIND(CH_TX), .DEPTH(TX_DEPTH)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .level       (tx_level),
    .act         (host_wr),
    .ack_n       (tx_ack_n),
    .req         (tx_req),
    .plain_start (plain_go[DIR_WR]),
    .xfer        (tx_push),
    .err         (tx_err)
  );

  dma_hs_decode #(.NDIR(2)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .go      (plain_go),
    .ram_sel (ram_sel),
    .reg_sel (reg_sel),
    .ram_stb (ram_stb),
    .reg_stb (reg_stb)
  );

  assign ram_rd = ram_stb[DIR_RD];
  assign ram_wr = ram_stb[DIR_WR];
  assign reg_rd = reg_stb[DIR_RD];
  assign reg_wr = reg_stb[DIR_WR];
endmodule

// File: rtl/dma_fifo_handshake_chk.sv
module dma_fifo_handshake_chk #(
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned TX_DEPTH = 16,
  localparam int unsigned RX_LW   = $clog2(RX_DEPTH + 1),
  localparam int unsigned TX_LW   = $clog2(TX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [RX_LW-1:0] rx_level,
  input logic [TX_LW-1:0] tx_level,
  input logic             host_rd,
  input logic             host_wr,
  input logic             rx_ack_n,
  input logic             tx_ack_n,
  input logic             rx_req,
  input logic             tx_req,
  input logic             rx_pop,
  input logic             tx_push,
  input logic             ram_rd,
  input logic             ram_wr,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic             rx_err,
  input logic             tx_err
);
  assert_rx_empty_noreq_R1: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |-> !rx_req);
  assert_rx_last_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_level == RX_LW'(1) && host_rd && !rx_ack_n) |-> !rx_req);
  assert_tx_full_noreq_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_level >= TX_LW'(TX_DEPTH)) |-> !tx_req);
  assert_tx_last_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_level == TX_LW'(TX_DEPTH - 1) && host_wr && !tx_ack_n) |-> !tx_req);
  assert_pop_no_decode_R5: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> !(ram_rd || reg_rd));
  assert_push_no_decode_R6: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> !(ram_wr || reg_wr));
  assert_pop_needs_word_R7: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(rx_level) != '0);
  assert_rx_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> rx_err);
  assert_push_needs_slot_R8: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(tx_level) < TX_LW'(TX_DEPTH));
  assert_tx_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    tx_err |=> tx_err);
  assert_one_rd_target_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_pop, ram_rd, reg_rd}));
  assert_one_wr_target_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_push, ram_wr, reg_wr}));
  assert_pop_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !rx_pop);
  assert_push_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    tx_push |=> !tx_push);
endmodule

bind dma_fifo_handshake dma_fifo_handshake_chk #(
  .RX_DEPTH(RX_DEPTH),
  .TX_DEPTH(TX_DEPTH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_level (rx_level),
  .tx_level (tx_level),
  .host_rd  (host_rd),
  .host_wr  (host_wr),
  .rx_ack_n (rx_ack_n),
  .tx_ack_n (tx_ack_n),
  .rx_req   (rx_req),
  .tx_req   (tx_req),
  .rx_pop   (rx_pop),
  .tx_push  (tx_push),
  .ram_rd   (ram_rd),
  .ram_wr   (ram_wr),
  .reg_rd   (reg_rd),
  .reg_wr   (reg_wr),
  .rx_err   (rx_err),
  .tx_err   (tx_err)
);

// File: tb/dma_fifo_handshake_test.sv
`timescale 1ns/1ps
module dma_fifo_handshake_test;
  localparam int unsigned RXD = 4;
  localparam int unsigned TXD = 5;
  localparam int unsigned RLW = $clog2(RXD + 1);
  localparam int unsigned TLW = $clog2(TXD + 1);
  localparam int unsigned MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RLW-1:0] rx_level = '0;
  logic [TLW-1:0] tx_level = '0;
  logic host_rd = 1'b0, host_wr = 1'b0, ram_sel = 1'b0, reg_sel = 1'b0;
  logic rx_ack_n = 1'b1, tx_ack_n = 1'b1;
  logic rx_req, tx_req, rx_pop, tx_push, ram_rd, ram_wr, reg_rd, reg_wr, rx_err, tx_err;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic prev_rd = 1'b0, prev_wr = 1'b0;
  logic e_pop, e_push, e_ram_rd, e_ram_wr, e_reg_rd, e_reg_wr;
  logic e_rx_err = 1'b0, e_tx_err = 1'b0;

  always #10 clk = ~clk;

  dma_fifo_handshake #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) uut (
    .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
    .host_rd(host_rd), .host_wr(host_wr), .ram_sel(ram_sel), .reg_sel(reg_sel),
    .rx_ack_n(rx_ack_n), .tx_ack_n(tx_ack_n), .rx_req(rx_req), .tx_req(tx_req),
    .rx_pop(rx_pop), .tx_push(tx_push), .ram_rd(ram_rd), .ram_wr(ram_wr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .rx_err(rx_err), .tx_err(tx_err));

  function automatic logic exp_rx_req(input logic [RLW-1:0] lv, input logic rd, input logic ackn);
    return (lv != 0) && !(lv == 1 && rd && !ackn);
  endfunction

  function automatic logic exp_tx_req(input logic [TLW-1:0] lv, input logic wr, input logic ackn);
    int unsigned room = (lv >= TXD) ? 0 : TXD - lv;
    return (room != 0) && !(room == 1 && wr && !ackn);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // One cycle: drive at negedge, check requests, clock, check strobes.
  task automatic step(input logic rd, input logic wr, input logic rakn,
                      input logic takn, input logic msel, input logic rsel);
    logic srd, swr;
    host_rd = rd; host_wr = wr; rx_ack_n = rakn; tx_ack_n = takn;
    ram_sel = msel; reg_sel = rsel;
    #1;
    chk("R1 R2 rx_req", rx_req, exp_rx_req(rx_level, rd, rakn));
    chk("R3 R4 tx_req", tx_req, exp_tx_req(tx_level, wr, takn));
    srd = rd && !prev_rd;
    swr = wr && !prev_wr;
    e_pop    = srd && !rakn && (rx_level != 0);
    e_push   = swr && !takn && (tx_level < TXD);
    e_rx_err = e_rx_err | (srd && !rakn && (rx_level == 0));
    e_tx_err = e_tx_err | (swr && !takn && (tx_level >= TXD));
    e_ram_rd = srd && rakn && msel;
    e_reg_rd = srd && rakn && !msel && rsel;
    e_ram_wr = swr && takn && msel;
    e_reg_wr = swr && takn && !msel && rsel;
    @(posedge clk);
    prev_rd = rd; prev_wr = wr;
    @(negedge clk);
    chk("R5 R7 R11 rx_pop", rx_pop, e_pop);
    chk("R6 R8 R11 tx_push", tx_push, e_push);
    chk("R9 ram_rd", ram_rd, e_ram_rd);
    chk("R9 reg_rd", reg_rd, e_reg_rd);
    chk("R9 ram_wr", ram_wr, e_ram_wr);
    chk("R9 reg_wr", reg_wr, e_reg_wr);
    chk("R7 rx_err", rx_err, e_rx_err);
    chk("R8 tx_err", tx_err, e_tx_err);
    if (rx_pop && rx_level != 0) rx_level = rx_level - 1'b1;
    if (tx_push && tx_level < TXD) tx_level = tx_level + 1'b1;
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rx_pop", rx_pop, 1'b0);
    chk("R10 tx_push", tx_push, 1'b0);
    chk("R10 rx_err", rx_err, 1'b0);
    chk("R10 tx_err", tx_err, 1'b0);
    chk("R10 ram_rd", ram_rd | reg_rd | ram_wr | reg_wr, 1'b0);
    rst = 1'b0;
    step(0, 0, 1, 1, 0, 0);

    // R2 R5 R11: acked read of the last word with both selects high, held
    rx_level = 1;
    step(1, 0, 0, 1, 1, 1);
    step(1, 0, 0, 1, 1, 1);
    step(1, 0, 0, 1, 1, 1);
    step(0, 0, 1, 1, 0, 0);
    // R7: acked read on empty receive FIFO
    step(1, 0, 0, 1, 1, 0);
    step(0, 0, 1, 1, 0, 0);
    // R4 R6: acked write into the last slot, then R8 on full
    tx_level = TXD - 1;
    step(0, 1, 1, 0, 1, 1);
    step(0, 0, 1, 1, 0, 0);
    step(0, 1, 1, 0, 0, 1);
    step(0, 0, 1, 1, 0, 0);
    // R9: unacked accesses via decode
    rx_level = 2;
    step(1, 0, 1, 1, 1, 0);
    step(0, 0, 1, 1, 0, 0);
    step(1, 1, 1, 1, 0, 1);
    step(0, 0, 1, 1, 0, 0);
    step(1, 1, 1, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    // R1 R3 with deeper levels
    tx_level = 0;
    rx_level = RXD;
    step(0, 0, 0, 0, 0, 0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0 && rx_level < RXD) rx_level = rx_level + 1'b1;
      if ($urandom_range(0, 3) == 0 && tx_level > 0) tx_level = tx_level - 1'b1;
      step(($urandom_range(0, 2) != 0) ? !host_rd | ($urandom_range(0, 1) == 1) : 1'b0,
           ($urandom_range(0, 2) != 0) ? !host_wr | ($urandom_range(0, 1) == 1) : 1'b0,
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1));
    end

    finished = 1'b1;
    summary();
  end
endmodule